// File: doc/BRIEF.md
# Misaligned Load Merge Unit

This unit sits between a processor load port and a memory bus that can only read whole aligned words. A load request names a byte address and a size of one, two or four bytes. If every requested byte lies inside one aligned bus word, the unit issues a single word read. If the bytes cross into the next word, it issues two word reads on back-to-back cycles. It keeps the first word, then shifts and ORs the two pieces into one right-justified result.

A per-request fault enable turns off splitting. With it set, any access whose address is not a multiple of its size is rejected with a fault. No bus read is issued for a rejected access. Byte order is little-endian. The unit handles one request at a time.

Top module: `mlm_top`

## Requirements
- R1: After reset the unit holds `done_o`, `fault_o` and `mem_req_o` low, `data_o` at zero and `req_ready_o` high.
- R2: The first bus read of an access uses word address `req_addr_i >> 2`.
- R3: An access whose bytes lie within one aligned word issues exactly one read. `done_o` is high in the third cycle after the accepting cycle, with `fault_o` low.
- R4: `data_o` holds the requested bytes right-justified and little-endian: the byte at the lowest address is in bits 7:0. All bits above the access size are zero.
- R5: `req_size_i` code 0 selects 1 byte, code 1 selects 2 bytes, and codes 2 and 3 select 4 bytes.
- R6: A straddling access issues exactly two reads on consecutive cycles. The second word address is the first plus one, wrapping at the top of the address space. `done_o` is high in the fourth cycle after the accepting cycle.
- R7: A 2-byte access at byte offset 3 straddles. One at offset 0, 1 or 2 uses a single read. A 4-byte access straddles at every nonzero offset. A 1-byte access never straddles.
- R8: With `fault_en_i` high at acceptance, a misaligned access gets `done_o` and `fault_o` high together in the cycle after acceptance, with `data_o` zero and no bus read. A 2-byte access is misaligned at odd offsets, a 4-byte access at any nonzero offset, and a 1-byte access never.
- R9: With `fault_en_i` low, no access faults.
- R10: `req_ready_o` is low from the cycle after acceptance until the cycle in which `done_o` is high. No read is issued while it is high.
- R11: `done_o` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Load request valid |
| req_ready_o | output | 1 | Unit idle and able to accept |
| req_addr_i | input | ADDR_W | Byte address |
| req_size_i | input | 2 | Access size code |
| fault_en_i | input | 1 | Fault on misalignment instead of splitting |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Access rejected as misaligned, valid with done_o |
| data_o | output | DATA_W | Right-justified load result |
| mem_req_o | output | 1 | Bus word read request |
| mem_addr_o | output | ADDR_W-2 | Bus word address |
| mem_rdata_i | input | DATA_W | Read data, valid the cycle after the request |

## Verification
The bench builds the unit with ADDR_W = 12 and DATA_W = 32. The byte space is then small enough that random addresses hit every offset and size pairing many times. Directed loads at byte 0xFFF make the second read of a straddling access wrap from word 0x3FF to word 0. Each access is run with fault mode both on and off, so splitting and rejection are compared on the same addresses.

// File: rtl/mlm_pkg.sv
package mlm_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD0  = 2'd1,
    ST_RD1  = 2'd2,
    ST_CAP  = 2'd3
  } state_e;
endpackage

// File: rtl/mlm_decode.sv
module mlm_decode #(
  parameter  int BYTES = 4,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [OFF_W-1:0]  off_i,
  input  mlm_pkg::size_e    size_i,
  output logic [OFF_W:0]    nbytes_o,
  output logic              straddle_o,
  output logic              misaligned_o
);
  import mlm_pkg::*;

  logic [OFF_W:0] span;
  logic [OFF_W:0] nm1;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: nbytes_o = (OFF_W+1)'(1);
      SZ_HALF: nbytes_o = (OFF_W+1)'(2);
      default: nbytes_o = (OFF_W+1)'(BYTES);
    endcase
  end

  assign span         = {1'b0, off_i} + nbytes_o;
  assign straddle_o   = span > (OFF_W+1)'(BYTES);
  assign nm1          = nbytes_o - 1'b1;
  assign misaligned_o = |({1'b0, off_i} & nm1);
endmodule

// File: rtl/mlm_ctrl.sv
module mlm_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic fault_en_i,
  input  logic misaligned_i,
  input  logic split_i,
  output logic req_ready_o,
  output logic accept_o,
  output logic flt_o,
  output logic mem_req_o,
  output logic second_o,
  output logic hold_o,
  output logic cap_o,
  output logic done_o,
  output logic fault_o
);
  import mlm_pkg::*;

  state_e state_q, state_d;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept_o    = req_valid_i & req_ready_o;
  assign flt_o       = accept_o & fault_en_i & misaligned_i;
  assign mem_req_o   = (state_q == ST_RD0) | (state_q == ST_RD1);
  assign second_o    = (state_q == ST_RD1);
  assign hold_o      = (state_q == ST_RD1); // first word arrives while second is requested
  assign cap_o       = (state_q == ST_CAP);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_o && !flt_o) state_d = ST_RD0;
      ST_RD0:  state_d = split_i ? ST_RD1 : ST_CAP;
      ST_RD1:  state_d = ST_CAP;
      ST_CAP:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= cap_o | flt_o;
      fault_o <= flt_o;
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  fault_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o);
  // R3
  result_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o) |-> $past(mem_req_o, 2));
  // R10
  no_read_when_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);
endmodule

// File: rtl/mlm_merge.sv
module mlm_merge #(
  parameter  int DATA_W = 32,
  localparam int BYTES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [OFF_W:0]    nbytes_i,
  input  logic              split_i,
  input  logic              hold_i,
  input  logic              cap_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] first_q;
  logic [DATA_W-1:0] lo_word, hi_word, mask, merged;
  logic [OFF_W+2:0]  lo_sh;
  logic [OFF_W+3:0]  hi_sh;
  logic [OFF_W:0]    hi_bytes;

  for (genvar b = 0; b < BYTES; b++) begin : g_mask
    assign mask[8*b +: 8] = {8{(OFF_W+1)'(b) < nbytes_i}};
  end

  assign lo_word  = split_i ? first_q : rdata_i;
  assign hi_word  = split_i ? rdata_i : '0;
  assign hi_bytes = (OFF_W+1)'(BYTES) - {1'b0, off_i};
  assign lo_sh    = {off_i, 3'b000};
  assign hi_sh    = {hi_bytes, 3'b000};
  assign merged   = ((lo_word >> lo_sh) | (hi_word << hi_sh)) & mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= '0;
      data_o  <= '0;
    end else begin
      if (hold_i) first_q <= rdata_i;
      if (clr_i)      data_o <= '0;
      else if (cap_i) data_o <= merged;
    end
  end
endmodule

// File: rtl/mlm_top.sv
module mlm_top #(
  parameter  int ADDR_W  = 32,
  parameter  int DATA_W  = 32,
  localparam int BYTES   = DATA_W / 8,
  localparam int OFF_W   = $clog2(BYTES),
  localparam int WADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [1:0]         req_size_i,
  input  logic               fault_en_i,
  output logic               done_o,
  output logic               fault_o,
  output logic [DATA_W-1:0]  data_o,
  output logic               mem_req_o,
  output logic [WADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0]  mem_rdata_i
);
  import mlm_pkg::*;

  logic [ADDR_W-1:0] addr_q;
  size_e             size_q;
  logic              accept, flt, second, hold, cap;
  logic [OFF_W:0]    nb_live, nb_q;
  logic              spl_live, mis_live, spl_q, mis_q;

  // live decode judges the fault at acceptance; held decode steers the access
  mlm_decode #(.BYTES(BYTES)) u_dec_live (
    .off_i(req_addr_i[OFF_W-1:0]), .size_i(size_e'(req_size_i)),
    .nbytes_o(nb_live), .straddle_o(spl_live), .misaligned_o(mis_live));

  mlm_decode #(.BYTES(BYTES)) u_dec_held (
    .off_i(addr_q[OFF_W-1:0]), .size_i(size_q),
    .nbytes_o(nb_q), .straddle_o(spl_q), .misaligned_o(mis_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      size_q <= SZ_BYTE;
    end else if (accept) begin
      addr_q <= req_addr_i;
      size_q <= size_e'(req_size_i);
    end
  end

  mlm_ctrl u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .fault_en_i,
    .misaligned_i(mis_live), .split_i(spl_q),
    .req_ready_o, .accept_o(accept), .flt_o(flt), .mem_req_o,
    .second_o(second), .hold_o(hold), .cap_o(cap), .done_o, .fault_o);

  mlm_merge #(.DATA_W(DATA_W)) u_merge (
    .clk_i, .rst_ni, .off_i(addr_q[OFF_W-1:0]), .nbytes_i(nb_q),
    .split_i(spl_q), .hold_i(hold), .cap_i(cap), .clr_i(flt),
    .rdata_i(mem_rdata_i), .data_o);

  assign mem_addr_o = addr_q[ADDR_W-1:OFF_W] + WADDR_W'(second);

  // R6
  split_addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |-> mem_addr_o == $past(mem_addr_o) + 1'b1);
  // R6
  burst_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |=> !mem_req_o);
  // R7
  byte_never_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && size_q == SZ_BYTE) |-> !spl_q && !mis_q);
  // R8
  fault_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt |=> !mem_req_o);
  // R5
  size_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> $countones(nb_live) == 1);
  // R7
  straddle_reads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !flt && spl_live |=> ##1 mem_req_o ##1 !req_ready_o);
endmodule

// File: tb/mlm_top_bench.sv
`timescale 1ns/1ps
module mlm_top_bench;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic          fault_en = 1'b0;
  logic          done, fault;
  logic [DW-1:0] data;
  logic          mem_req;
  logic [AW-3:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  int req_cnt = 0;
  logic [AW-3:0] req_seen [2];
  bit finished = 0;

  always #10 clk = ~clk;

  mlm_top #(.ADDR_W(AW), .DATA_W(DW)) u_mlm_top (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_size_i(req_size), .fault_en_i(fault_en),
    .done_o(done), .fault_o(fault), .data_o(data),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata));

  function automatic logic [31:0] mem_word(input logic [AW-3:0] wa);
    logic [31:0] k;
    k = {wa, 6'h15} * 32'h9E37_79B1;
    return k ^ 32'hC3A5_0F1E;
  endfunction

  function automatic logic [7:0] byte_at(input logic [AW-1:0] a);
    logic [31:0] w;
    w = mem_word(a[AW-1:2]);
    return w[8*a[1:0] +: 8];
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      if (req_cnt < 2) req_seen[req_cnt] = mem_addr;
      req_cnt = req_cnt + 1;
      mem_rdata <= mem_word(mem_addr);
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_access(input logic [AW-1:0] a, input logic [1:0] sz, input bit fen);
    int nb, lat, want_lat, want_reqs;
    logic [1:0] off;
    bit mis, spl, exp_flt, seen_busy_ready;
    logic [31:0] exp_d;
    nb  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    off = a[1:0];
    mis = (int'(off) & (nb - 1)) != 0;
    spl = (int'(off) + nb) > 4;
    exp_flt = fen && mis;
    want_lat  = exp_flt ? 1 : (spl ? 4 : 3);
    want_reqs = exp_flt ? 0 : (spl ? 2 : 1);
    exp_d = '0;
    if (!exp_flt)
      for (int k = 0; k < nb; k++) exp_d[8*k +: 8] = byte_at(a + AW'(k));

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_cnt   = 0;
    req_valid = 1'b1;
    req_addr  = a;
    req_size  = sz;
    fault_en  = fen;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    seen_busy_ready = 0;
    while (!done && lat < 8) begin
      if (req_ready) seen_busy_ready = 1;
      @(negedge clk);
      lat++;
    end
    // R3 R6 R8: latency and fault flag
    check(lat == want_lat, exp_flt ? "R8 latency" : (spl ? "R6 latency" : "R3 latency"), lat, want_lat);
    check(fault == exp_flt, fen ? "R8 fault flag" : "R9 no fault", fault, exp_flt);
    // R4 R5: data
    check(data == exp_d, "R4 R5 data", data, exp_d);
    // R7: read count
    check(req_cnt == want_reqs, "R7 read count", req_cnt, want_reqs);
    if (want_reqs >= 1)
      check(req_seen[0] == a[AW-1:2], "R2 first word addr", 32'(req_seen[0]), 32'(a[AW-1:2]));
    if (want_reqs == 2)
      check(req_seen[1] == a[AW-1:2] + 1'b1, "R6 second word addr", 32'(req_seen[1]), 32'(a[AW-1:2] + 1'b1));
    // R10
    check(req_ready && !seen_busy_ready, "R10 ready", req_ready, 1);
    @(negedge clk);
    // R11
    check(!done, "R11 done pulse", done, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1
    check(!done && !fault && !mem_req && req_ready && data == '0, "R1 reset state",
          {done, fault, mem_req, req_ready}, 4'b0001);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && req_ready && !mem_req, "R1 after release", {done, req_ready, mem_req}, 3'b010);

    for (int f = 0; f < 2; f++)
      for (int s = 0; s < 4; s++)
        for (int o = 0; o < 4; o++)
          do_access(AW'(12'h240 + o), 2'(s), f[0]);
    // wrap at top of space: R6 R7
    do_access(12'hFFF, 2'd1, 1'b0);
    do_access(12'hFFD, 2'd2, 1'b0);
    do_access(12'hFFF, 2'd3, 1'b0);
    do_access(12'hFFF, 2'd0, 1'b1);
    do_access(12'hFFF, 2'd2, 1'b1);
    for (int i = 0; i < 400; i++)
      do_access(AW'($urandom), 2'($urandom), 1'($urandom));

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule